// File: doc/BRIEF.md
# Reset Release and Boot Strap Capture

This block turns a raw, asynchronous, active-low reset pin into a clean internal reset for the core clock domain. Assertion takes effect at once, without a clock. Release is retimed through two flops, so the internal reset always ends on a clock edge. In the same sequence the block samples a handful of configuration straps. It holds the decoded mode bits until the reset pin is pulled low again, and then it gives a single pulse that tells the processor to begin fetching from its reset vector.

Most straps are captured on the clock edge where the internal reset releases. These cover the isolation request (two pins, both low to enter), the divide-by-two clock select, and the reserved test-mode pin. The address-enable strap is captured one clock later. The fetch-start pulse comes a fixed number of half-periods after release; with the default of 13 half-periods it lands 7 full clocks after the internal reset rises.

Top module: `reset_strap_unit`

## Requirements
- R1: While rst_in_n is low, core_rst_n is 0 and iso_mode, div2_sel, pll_off, addr_gate_en, test_mode and fetch_go are all 0, including between clock edges.
- R2: After rst_in_n goes high, core_rst_n stays 0 through the first rising clk edge and becomes 1 at the second rising edge.
- R3: iso_mode becomes 1 exactly when strap_iso_a_n and strap_iso_b_n are both 0 at the clock edge where core_rst_n rises; otherwise it stays 0.
- R4: Once captured, iso_mode, div2_sel, pll_off, test_mode and addr_gate_en keep their values whatever the straps do afterwards, until rst_in_n is next driven low.
- R5: div2_sel and pll_off both become 1 when strap_div_n is 0 at the edge where core_rst_n rises, and both stay 0 when it is 1.
- R6: addr_gate_en takes the value of strap_addr_en at the clock edge one after the edge where core_rst_n rises; the strap level at the release edge itself has no effect.
- R7: test_mode becomes 1 when strap_uzero_n is 0 at the edge where core_rst_n rises.
- R8: fetch_go is high for exactly one clock cycle, starting at the 7th rising edge after the edge where core_rst_n rises (FETCH_HALF = 13 half-periods, rounded up to whole clocks). It does not pulse again until after the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_in_n | input | 1 | Asynchronous active-low reset pin |
| strap_iso_a_n | input | 1 | Isolation request strap A, low requests |
| strap_iso_b_n | input | 1 | Isolation request strap B, low requests |
| strap_div_n | input | 1 | Low selects divide-by-two clock and PLL off |
| strap_addr_en | input | 1 | High lets per-region bits disable the address phase |
| strap_uzero_n | input | 1 | Low selects the reserved test mode |
| core_rst_n | output | 1 | Synchronized internal reset, active low |
| iso_mode | output | 1 | All outputs to be floated |
| div2_sel | output | 1 | Core clock is the input divided by two |
| pll_off | output | 1 | PLL disabled |
| addr_gate_en | output | 1 | Address-phase disable bits honoured |
| test_mode | output | 1 | Reserved test mode latched |
| fetch_go | output | 1 | One-cycle pulse that starts instruction fetch |

## Verification
Two captures fall on adjacent edges: the main strap capture at release and the late address-strap capture one clock later. The bench tells them apart by driving the address strap to the opposite level at the release edge, setting it to the wanted level only for the following edge, and inverting every other strap right after release. A design that sampled on the wrong edge, or kept sampling, shows the wrong mode bit. Each of the 32 strap patterns is followed directly by the next reset, so a stale mode bit carried across a re-reset is also caught.

// File: rtl/reset_strap_unit.sv
`timescale 1ns/1ps
module reset_strap_unit #(
  parameter int FETCH_HALF = 13
) (
  input  logic clk,
  input  logic rst_in_n,
  input  logic strap_iso_a_n,
  input  logic strap_iso_b_n,
  input  logic strap_div_n,
  input  logic strap_addr_en,
  input  logic strap_uzero_n,
  output logic core_rst_n,
  output logic iso_mode,
  output logic div2_sel,
  output logic pll_off,
  output logic addr_gate_en,
  output logic test_mode,
  output logic fetch_go
);
  localparam int FETCH_CYC = (FETCH_HALF + 1) / 2;
  localparam int CW = $clog2(FETCH_CYC + 2);
  localparam logic [CW-1:0] CNT_END = CW'(FETCH_CYC + 1);
  localparam logic [CW-1:0] CNT_GO  = CW'(FETCH_CYC);

  logic sync1, sync2, late_d;
  logic iso_q, div_q, test_q, addr_q;
  logic [CW-1:0] cnt;

  wire release_edge = sync1 & ~sync2;

  always_ff @(posedge clk or negedge rst_in_n)
    if (!rst_in_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= 1'b1;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_in_n)
    if (!rst_in_n) begin
      iso_q  <= 1'b0;
      div_q  <= 1'b0;
      test_q <= 1'b0;
    end else if (release_edge) begin
      iso_q  <= ~strap_iso_a_n & ~strap_iso_b_n;
      div_q  <= ~strap_div_n;
      test_q <= ~strap_uzero_n;
    end

  always_ff @(posedge clk or negedge rst_in_n)
    if (!rst_in_n) begin
      late_d <= 1'b0;
      addr_q <= 1'b0;
    end else begin
      late_d <= release_edge;
      if (late_d) addr_q <= strap_addr_en;
    end

  always_ff @(posedge clk or negedge rst_in_n)
    if (!rst_in_n)
      cnt <= '0;
    else if (sync2 && cnt != CNT_END)
      cnt <= cnt + 1'b1;

  assign core_rst_n   = sync2;
  assign iso_mode     = iso_q;
  assign div2_sel     = div_q;
  assign pll_off      = div_q;
  assign test_mode    = test_q;
  assign addr_gate_en = addr_q;
  assign fetch_go     = sync2 && (cnt == CNT_GO);
endmodule

module reset_strap_unit_sva (
  input logic clk,
  input logic rst_in_n,
  input logic core_rst_n,
  input logic iso_mode,
  input logic div2_sel,
  input logic pll_off,
  input logic addr_gate_en,
  input logic test_mode,
  input logic fetch_go
);
  always @(negedge clk)
    if (!rst_in_n)
      assert_reset_clear_R1: assert (!core_rst_n && !iso_mode && !div2_sel && !pll_off
                                     && !addr_gate_en && !test_mode && !fetch_go);

  assert_release_sync_R2: assert property (@(posedge clk) disable iff (!rst_in_n)
    $rose(core_rst_n) |-> $past(rst_in_n));

  assert_iso_sticky_R4: assert property (@(posedge clk) disable iff (!rst_in_n)
    iso_mode |=> iso_mode);

  assert_modes_hold_R4: assert property (@(posedge clk) disable iff (!rst_in_n)
    core_rst_n |=> ($stable(div2_sel) && $stable(test_mode) && $stable(iso_mode) && $stable(pll_off)));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_in_n)
    (core_rst_n && $past(core_rst_n)) |=> $stable(addr_gate_en));

  assert_fetch_single_R8: assert property (@(posedge clk) disable iff (!rst_in_n)
    fetch_go |=> !fetch_go);

  assert_fetch_after_rst_R8: assert property (@(posedge clk) disable iff (!rst_in_n)
    fetch_go |-> core_rst_n);
endmodule

bind reset_strap_unit reset_strap_unit_sva chk (
  .clk(clk), .rst_in_n(rst_in_n), .core_rst_n(core_rst_n), .iso_mode(iso_mode),
  .div2_sel(div2_sel), .pll_off(pll_off), .addr_gate_en(addr_gate_en),
  .test_mode(test_mode), .fetch_go(fetch_go)
);

// File: tb/reset_strap_unit_test.sv
`timescale 1ns/1ps
module reset_strap_unit_test;
  logic clk = 1'b0;
  logic rst_in_n = 1'b0;
  logic s_iso_a = 1'b1, s_iso_b = 1'b1, s_div = 1'b1, s_addr = 1'b1, s_uz = 1'b1;
  logic core_rst_n, iso_mode, div2_sel, pll_off, addr_gate_en, test_mode, fetch_go;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  reset_strap_unit uut (
    .clk(clk), .rst_in_n(rst_in_n),
    .strap_iso_a_n(s_iso_a), .strap_iso_b_n(s_iso_b), .strap_div_n(s_div),
    .strap_addr_en(s_addr), .strap_uzero_n(s_uz),
    .core_rst_n(core_rst_n), .iso_mode(iso_mode), .div2_sel(div2_sel),
    .pll_off(pll_off), .addr_gate_en(addr_gate_en), .test_mode(test_mode),
    .fetch_go(fetch_go)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_cleared(input string req);
    check(req, "core_rst_n", core_rst_n, 1'b0);
    check(req, "iso_mode", iso_mode, 1'b0);
    check(req, "div2_sel", div2_sel, 1'b0);
    check(req, "pll_off", pll_off, 1'b0);
    check(req, "addr_gate_en", addr_gate_en, 1'b0);
    check(req, "test_mode", test_mode, 1'b0);
    check(req, "fetch_go", fetch_go, 1'b0);
  endtask

  task automatic run_pattern(input logic [4:0] c);
    logic e_iso, e_div, e_test, e_addr;
    e_iso  = ~c[0] & ~c[1];
    e_div  = ~c[2];
    e_addr = c[3];
    e_test = ~c[4];
    @(negedge clk);
    #2 rst_in_n = 1'b0;
    {s_uz, s_addr, s_div, s_iso_b, s_iso_a} = c;
    #1 check_cleared("R1");
    repeat (3) @(negedge clk);
    check_cleared("R1");
    rst_in_n = 1'b1;
    s_addr = ~c[3];
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) check("R2", "core_rst_n first edge", core_rst_n, 1'b0);
      if (i == 2) begin
        check("R2", "core_rst_n second edge", core_rst_n, 1'b1);
        check("R3", "iso_mode", iso_mode, e_iso);
        check("R5", "div2_sel", div2_sel, e_div);
        check("R5", "pll_off", pll_off, e_div);
        check("R7", "test_mode", test_mode, e_test);
        s_addr = c[3];
        s_iso_a = ~c[0]; s_iso_b = ~c[1]; s_div = ~c[2]; s_uz = ~c[4];
      end
      if (i == 3) begin
        check("R6", "addr_gate_en", addr_gate_en, e_addr);
        s_addr = ~c[3];
      end
      check("R8", $sformatf("fetch_go idx %0d", i), fetch_go, (i == 9));
    end
    check("R4", "iso_mode held", iso_mode, e_iso);
    check("R4", "div2_sel held", div2_sel, e_div);
    check("R4", "pll_off held", pll_off, e_div);
    check("R4", "test_mode held", test_mode, e_test);
    check("R4", "addr_gate_en held", addr_gate_en, e_addr);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_cleared("R1");
    for (int c = 0; c < 32; c++) run_pattern(5'(c));
    for (int c = 31; c >= 0; c -= 5) run_pattern(5'(c));
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule